// File: doc/BRIEF.md
# Addressed SPI Slave Frame Controller

This block is the serial front end of a slave that shares a multi-drop SPI bus with other devices. Each frame is 16 bits long and is sent MSB first. An 8-bit instruction comes first: two chip-address bits, one read/write bit and a 5-bit register address. Eight data bits follow. The two address bits are compared against strap inputs. While the frame for this chip is shifting in, the block shifts out a check byte. That byte carries a sticky flag which reports whether the previous access to this chip was invalid.

The serial pins are synchronised into the system clock domain. Edges of the serial clock are detected by oversampling. A register write leaves the block through a parallel port as a single-cycle strobe with address and data. The write is issued only after select rises, and only for a complete, well-formed frame addressed to this chip. The serial output has a separate enable so that an external pad can tri-state it. The enable stays low until the chip address has been confirmed.

Top module: `addr_spi_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sdo_oe` and `wr_en` go low, the frame state returns to waiting and the invalid flag clears. The first matched frame after reset returns check byte 8'hA0.
- R2: While `ss_n` is low, `sdi` is sampled on falling `sck` edges, MSB first. Frame slot 0 is instruction bit 7 and slot 15 is data bit 0. Instruction bits [7:6] are the chip address, bit 5 is write (1) or read (0), and bits [4:0] are the register address.
- R3: `sdo` changes only after rising `sck` edges. Frame slots 2 to 9 carry the check byte MSB first, and slots 10 onward carry 0.
- R4: `sdo_oe` is low during slots 0 and 1. It goes high from slot 2 only when instruction bits [7:6] equal `chip_id`.
- R5: On an address mismatch, `sdo_oe` stays low for the whole frame. No write is issued and the invalid flag keeps its value.
- R6: A write is committed only after `ss_n` rises, as a one-cycle `wr_en` pulse with `wr_addr` = instruction bits [4:0] and `wr_data` = the data byte. `wr_en` never pulses while `ss_n` is low.
- R7: The check byte is 8'b1010_000x, where x is the invalid flag left by the previous matched frame. Reporting the flag once clears it.
- R8: A matched frame whose falling-edge count at the rise of `ss_n` is not exactly 16 is invalid. It sets the flag and is not committed.
- R9: A matched frame naming a register address of `NUM_REGS` or above is invalid. It sets the flag and writes nothing. Address `NUM_REGS`-1 is valid.
- R10: When `ss_n` is high, the frame logic returns to the wait state. A frame aborted early leaves no trace, and the next frame is decoded from slot 0.
- R11: A matched, complete read frame (bit 5 = 0) to a valid address issues no write and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| chip_id | input | 2 | Strapped chip address |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; the pad is high-impedance when low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
A fault in the bit counter or the shift register surfaces at the rise of `ss_n`. It appears either as a missing write, a wrong address or data on the strobe, or a spurious write. The next matched frame then also shows the wrong flag bit in its check byte. A fault in the address-match state shows within the same frame, as early as slot 2, because `sdo_oe` is asserted for a foreign frame or not asserted for this chip's frame. A stuck or never-clearing invalid flag shows up one frame later, in the low bit of the check byte.

// File: rtl/spi_fc_pkg.sv
// Shared constants and types for the addressed SPI slave.
// Assumes a fixed 16-slot frame: 8-bit instruction then 8-bit data.
package spi_fc_pkg;
    localparam int INSTR_BITS = 8;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = INSTR_BITS + DATA_BITS;
    localparam int REG_AW     = 5;
    localparam int ID_W       = 2;
    localparam int CNT_MAX    = FRAME_BITS + 1;          // saturates: "too long"
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [7:0] CHK_BASE = 8'hA0;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_IGNORE = 2'd3
    } frame_st_t;
endpackage

// File: rtl/spi_fc_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes every pin is held for longer than STAGES+1 clock cycles.
module spi_fc_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the pin through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_fc_rx.sv
// Frame receiver: state machine, bit counter, shift register, address match.
// Assumes synchronised inputs and single-cycle edge strobes.
module spi_fc_rx
    import spi_fc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ss_n_s,
    input  logic                  ss_fall,
    input  logic                  sck_fall,
    input  logic                  sdi_s,
    input  logic [ID_W-1:0]       chip_id,
    output frame_st_t             state,
    output logic [CNT_W-1:0]      cnt,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  addr_take
);
    // track frame state, count falling edges and shift in data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_WAIT;
            cnt       <= '0;
            frame     <= '0;
            addr_take <= 1'b0;
        end else begin
            addr_take <= 1'b0;
            if (ss_n_s) begin
                state <= ST_WAIT;
                cnt   <= '0;
            end else begin
                if (ss_fall) state <= ST_ADDR;
                if (sck_fall) begin
                    frame <= {frame[FRAME_BITS-2:0], sdi_s};
                    if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + CNT_W'(1);
                    if (cnt == CNT_W'(1) && state == ST_ADDR) begin
                        if ({frame[0], sdi_s} == chip_id) begin
                            state     <= ST_ACTIVE;
                            addr_take <= 1'b1;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_fc_tx.sv
// Check-byte transmitter with output-enable control.
// Assumes addr_take pulses once per matched frame before slot 2.
module spi_fc_tx
    import spi_fc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ss_n_s,
    input  logic      sck_rise,
    input  frame_st_t state,
    input  logic      addr_take,
    input  logic      inv_flag,
    output logic      sdo,
    output logic      sdo_oe
);
    logic [7:0] chk_sr;

    // load the check byte on match and shift it out on rising sck edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_sr <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (ss_n_s) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (addr_take) begin
            chk_sr <= CHK_BASE | {7'd0, inv_flag};
        end else if (sck_rise && state == ST_ACTIVE) begin
            sdo    <= chk_sr[7];
            chk_sr <= {chk_sr[6:0], 1'b0};
            sdo_oe <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_fc_commit.sv
// Frame closing: validity decode, deferred register write, sticky invalid flag.
// Assumes state, cnt and frame still hold the closing frame during ss_rise.
module spi_fc_commit
    import spi_fc_pkg::*;
#(
    parameter int NUM_REGS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ss_rise,
    input  frame_st_t             state,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  flag_clr,
    output logic                  wr_en,
    output logic [REG_AW-1:0]     wr_addr,
    output logic [DATA_BITS-1:0]  wr_data,
    output logic                  inv_flag
);
    localparam int unsigned REG_LIM = NUM_REGS;

    logic [INSTR_BITS-1:0] instr;
    logic closing, len_ok, reg_ok, do_wr;

    // decode the closing frame
    always_comb begin
        instr   = frame[FRAME_BITS-1 -: INSTR_BITS];
        closing = ss_rise && (state == ST_ACTIVE);
        len_ok  = (cnt == CNT_W'(FRAME_BITS));
        reg_ok  = (32'(instr[REG_AW-1:0]) < REG_LIM);
        do_wr   = closing && len_ok && reg_ok && instr[REG_AW];
    end

    // issue the write strobe and maintain the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            inv_flag <= 1'b0;
        end else begin
            wr_en <= do_wr;
            if (do_wr) begin
                wr_addr <= instr[REG_AW-1:0];
                wr_data <= frame[DATA_BITS-1:0];
            end
            if (closing && !(len_ok && reg_ok)) inv_flag <= 1'b1;
            else if (flag_clr)                  inv_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/addr_spi_slave.sv
// Top of the addressed SPI slave: synchronises the pins, detects edges and
// wires receiver, transmitter and commit logic. Assumes sck phases last at
// least SYNC_STAGES+2 clock cycles.
module addr_spi_slave
    import spi_fc_pkg::*;
#(
    parameter int NUM_REGS    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ss_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic [ID_W-1:0]      chip_id,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic                 wr_en,
    output logic [REG_AW-1:0]    wr_addr,
    output logic [DATA_BITS-1:0] wr_data
);
    logic [2:0] pins_s;
    logic ss_n_s, sck_s, sdi_s, ss_d, sck_d;
    logic ss_rise, ss_fall, sck_rise, sck_fall;
    frame_st_t state;
    logic [CNT_W-1:0] cnt;
    logic [FRAME_BITS-1:0] frame;
    logic addr_take, inv_flag;

    spi_fc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n, sck, sdi}), .q(pins_s)
    );

    assign ss_n_s = pins_s[2];
    assign sck_s  = pins_s[1];
    assign sdi_s  = pins_s[0];

    // keep the previous synchronised select and clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            ss_d  <= ss_n_s;
            sck_d <= sck_s;
        end
    end

    // derive single-cycle edge strobes, serial clock gated by select
    always_comb begin
        ss_rise  = ss_n_s & ~ss_d;
        ss_fall  = ~ss_n_s & ss_d;
        sck_rise = sck_s & ~sck_d & ~ss_n_s;
        sck_fall = ~sck_s & sck_d & ~ss_n_s;
    end

    spi_fc_rx u_rx (
        .clk(clk), .rst_n(rst_n), .ss_n_s(ss_n_s), .ss_fall(ss_fall),
        .sck_fall(sck_fall), .sdi_s(sdi_s), .chip_id(chip_id),
        .state(state), .cnt(cnt), .frame(frame), .addr_take(addr_take)
    );

    spi_fc_tx u_tx (
        .clk(clk), .rst_n(rst_n), .ss_n_s(ss_n_s), .sck_rise(sck_rise),
        .state(state), .addr_take(addr_take), .inv_flag(inv_flag),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    spi_fc_commit #(.NUM_REGS(NUM_REGS)) u_commit (
        .clk(clk), .rst_n(rst_n), .ss_rise(ss_rise), .state(state),
        .cnt(cnt), .frame(frame), .flag_clr(addr_take),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inv_flag(inv_flag)
    );
endmodule

// File: rtl/addr_spi_slave_chk.sv
// Protocol checker bound into addr_spi_slave.
// Assumes it observes the synchronised select and the frame state.
module addr_spi_slave_chk
    import spi_fc_pkg::*;
#(
    parameter int NUM_REGS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n_s,
    input logic              ss_rise,
    input frame_st_t         state,
    input logic              sdo_oe,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr
);
    localparam int unsigned REG_LIM = NUM_REGS;

    p_oe_off_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_s |=> !sdo_oe);

    p_oe_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(state) == ST_ACTIVE);

    p_wr_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_wr_after_select_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ss_rise));

    p_wr_addr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> 32'(wr_addr) < REG_LIM);
endmodule

bind addr_spi_slave addr_spi_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ss_n_s(ss_n_s), .ss_rise(ss_rise),
    .state(state), .sdo_oe(sdo_oe), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tb_addr_spi_slave.sv
module tb_addr_spi_slave;
    localparam int HALF = 4;
    localparam int NREG = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [1:0] chip_id = 2'b10;
    logic sdo, sdo_oe, wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0, fails = 0, cyc = 0;
    int wr_cnt = 0;
    logic [4:0] last_a;
    logic [7:0] last_d;
    bit flag_m = 1'b0;

    always #4 clk = ~clk;

    addr_spi_slave dut (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .sdi(sdi),
        .chip_id(chip_id), .sdo(sdo), .sdo_oe(sdo_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // record every write strobe
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) begin
            wr_cnt <= wr_cnt + 1;
            last_a <= wr_addr;
            last_d <= wr_data;
        end
    end

    // watchdog
    always @(posedge clk) if (cyc > 150000) begin
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog act=%0d exp<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one frame as bus master; sample sdo/oe just before each falling edge
    task automatic run_frame(input logic [15:0] fr, input int nbits,
                             output logic [31:0] so, output logic [31:0] oe, output int mid);
        so = '0; oe = '0;
        ss_n = 1'b0;
        tick(2 * HALF);
        for (int k = 0; k < nbits; k++) begin
            sdi = (k < 16) ? fr[15-k] : 1'b0;
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            so[k] = sdo;
            oe[k] = sdo_oe;
            sck = 1'b0;
            tick(HALF);
        end
        tick(HALF);
        mid = wr_cnt;
        ss_n = 1'b1;
        tick(12);
    endtask

    // expected-value model from the requirements
    task automatic do_frame(input logic [15:0] fr, input int nbits);
        logic [31:0] so, oe, e_oe, e_so;
        int pre, mid;
        bit match, bad, wr;
        logic [7:0] cb;
        pre   = wr_cnt;
        match = (nbits >= 2) && (fr[15:14] == chip_id);
        cb    = 8'hA0 | {7'd0, flag_m};
        bad   = match && ((nbits != 16) || (int'(fr[12:8]) >= NREG));
        wr    = match && !bad && fr[13];
        e_oe = '0; e_so = '0;
        for (int k = 2; k < nbits; k++) begin
            e_oe[k] = match;
            if (match && k < 10) e_so[k] = cb[9-k];
        end
        run_frame(fr, nbits, so, oe, mid);
        chk(oe == e_oe, match ? "R4 oe" : "R5 oe mismatch", oe, e_oe);
        chk((so & e_oe) == e_so, "R3/R7 check byte", so & e_oe, e_so);
        chk(mid == pre, "R6 no write during shifting", mid - pre, 0);
        chk((wr_cnt - pre) == (wr ? 1 : 0),
            bad ? (nbits != 16 ? "R8 length" : "R9 reg range") :
            (!match ? "R5 ignored" : (fr[13] ? "R6 write" : "R11 read")),
            wr_cnt - pre, wr ? 1 : 0);
        if (wr) chk({last_a, last_d} == fr[12:0], "R2 write payload",
                    {last_a, last_d}, fr[12:0]);
        if (match) flag_m = bad;
    endtask

    initial begin
        void'($urandom(32'd2024));
        tick(10);
        chk(sdo_oe == 1'b0 && wr_en == 1'b0, "R1 reset outputs", {sdo_oe, wr_en}, 0);
        rst_n = 1'b1;
        tick(5);
        // directed cases
        do_frame({2'b10, 1'b1, 5'd3,  8'h5A}, 16);   // R1 first check byte A0
        do_frame({2'b10, 1'b0, 5'd7,  8'hFF}, 16);   // R11
        do_frame({2'b10, 1'b1, 5'd25, 8'h11}, 16);   // R9
        do_frame({2'b10, 1'b0, 5'd1,  8'h00}, 16);   // R7 flag reported
        do_frame({2'b10, 1'b0, 5'd1,  8'h00}, 16);   // R7 flag cleared
        do_frame({2'b01, 1'b1, 5'd2,  8'h33}, 16);   // R5
        do_frame({2'b10, 1'b1, 5'd2,  8'h44}, 12);   // R8 short
        do_frame({2'b11, 1'b1, 5'd2,  8'h55}, 16);   // R5 flag kept
        do_frame({2'b10, 1'b1, 5'd4,  8'h66}, 16);   // R7 shows flag
        do_frame({2'b10, 1'b1, 5'd4,  8'h77}, 17);   // R8 long
        do_frame({2'b10, 1'b1, 5'd0,  8'h00}, 1);    // R10 aborted
        do_frame({2'b10, 1'b1, 5'd19, 8'hC3}, 16);   // R9 boundary valid, R10
        do_frame({2'b10, 1'b1, 5'd20, 8'h3C}, 16);   // R9 boundary invalid
        chip_id = 2'b01;
        do_frame({2'b01, 1'b1, 5'd9,  8'hA5}, 16);
        do_frame({2'b10, 1'b1, 5'd9,  8'h5A}, 16);
        chip_id = 2'b10;
        // random frames
        for (int i = 0; i < 60; i++) begin
            logic [15:0] fr;
            int r, n;
            fr = 16'($urandom);
            r  = $urandom % 10;
            n  = (r == 0) ? 12 : (r == 1) ? 17 : 16;
            if ($urandom % 2 == 0) fr[15:14] = chip_id;
            do_frame(fr, n);
        end
        // R1 reset clears the sticky flag
        do_frame({2'b10, 1'b1, 5'd30, 8'h00}, 16);
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        flag_m = 1'b0;
        tick(4);
        do_frame({2'b10, 1'b0, 5'd5, 8'h00}, 16);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule